// File: doc/BRIEF.md
# MSI Capture and Interrupt Aggregator

This block gathers the interrupt sources of one PCIe root port into a single host interrupt line. Upstream logic presents every inbound memory write as an event with an address and a data word. When the address equals a programmable 32-bit target, the low data value is taken as a vector number, and the matching bit of a 32-bit vector status register is set. Four level-sensitive legacy INTx inputs are latched into a shared status register. That register also holds a single summary bit that records MSI activity. A mask register gates every source in the shared register. The unmasked, pending bits are ORed together and drive `host_irq` through a two-state machine.

Software reaches all registers through a flat 32-bit port. A write takes effect on the clock edge at which `reg_wr` is high. `reg_rdata` is a combinational decode of `reg_addr`.

Register byte offsets:
- 0x00 holds the vector status.
- 0x04 holds the shared status.
- 0x08 holds the mask.
- 0x0C holds the MSI target address.
- 0x10 is the debug register.

Any other offset reads as zero.

The interrupt machine has two states:
- `IRQ_IDLE` moves to `IRQ_ACTIVE` when any unmasked status bit is set.
- `IRQ_ACTIVE` returns to `IRQ_IDLE` when no unmasked status bit is set.
- `host_irq` is high exactly while the machine is in `IRQ_ACTIVE`.

Top module: `msi_irq_agg`

## Requirements
- R1: After reset, the vector status, shared status, target and debug registers read 0. The mask register reads 0x008F0000, so every source is masked. `host_irq` is 0.
- R2: An event with `msi_valid`=1, `msi_addr` equal to the target register and `msi_data`=N with N<32 sets bit N of the vector status register (offset 0x00) at that clock edge.
- R3: An event whose address differs from the target register changes no register.
- R4: Writing offset 0x00 clears each vector status bit written as one. Bits written as zero are unchanged.
- R5: When a capture of vector N and a write-one clear of bit N happen on the same edge, bit N ends up set.
- R6: Shared status bits 19..16 latch INTx inputs 3..0 (input i maps to bit 16+i). They are cleared by writing ones to offset 0x04, but a bit whose input is still high stays set.
- R7: Shared status bit 23 (the MSI summary) sets on every valid capture. It stays set until a one is written to bit 23 of offset 0x04. That write clears it only if the vector status register is zero at that edge and no capture occurs on the same edge.
- R8: The mask register (offset 0x08) stores only bits 23 and 19..16, and its other bits read 0. A source reaches `host_irq` only while its mask bit is 0.
- R9: `host_irq` equals the OR of all set, unmasked shared status bits, delayed by one clock.
- R10: A matching event with `msi_data` of 32 or more leaves the vector status and summary unchanged. It sets a sticky error flag at bit 0 of offset 0x10, and writes to offset 0x10 have no effect.
- R11: The target register (offset 0x0C) stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | Inbound memory-write event strobe |
| msi_addr | input | 32 | Address of the inbound write |
| msi_data | input | 32 | Data of the inbound write (vector number) |
| intx_lvl | input | 4 | Legacy INTx level inputs, bit i is source i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| host_irq | output | 1 | Host interrupt request |

## Verification
The hardest situations to reach are the two rules for the MSI summary bit:
- A summary clear must be refused while vector bits are still pending.
- A vector capture must win over a clear of the same bit on the same edge.

The stimulus reaches both by driving an event on `msi_valid` and a register write in the same cycle. It also attempts the summary clear both before and after draining the vector register. A behavioural model in the bench tracks every register and the delayed interrupt and is compared with the read port and `host_irq` on every clock.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    localparam int NUM_VEC     = 32;
    localparam int DATA_W      = 32;
    localparam int INTX_N      = 4;
    localparam int INTX_LSB    = 16;
    localparam int MSI_SUM_BIT = 23;
    localparam int REG_AW      = 5;

    localparam logic [REG_AW-1:0] OFS_VEC_STAT = 5'h00;
    localparam logic [REG_AW-1:0] OFS_IRQ_STAT = 5'h04;
    localparam logic [REG_AW-1:0] OFS_IRQ_MASK = 5'h08;
    localparam logic [REG_AW-1:0] OFS_MSI_TGT  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_DEBUG    = 5'h10;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/msi_vec_capture.sv
module msi_vec_capture #(
    parameter int NUM_VEC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic [DATA_W-1:0]  ev_addr,
    input  logic [DATA_W-1:0]  ev_data,
    input  logic [DATA_W-1:0]  tgt_addr,
    input  logic [NUM_VEC-1:0] clr_vec,
    output logic [NUM_VEC-1:0] status,
    output logic               hit,
    output logic               err
);
    localparam int IDX_W = $clog2(NUM_VEC);

    logic               addr_ok;
    logic               in_range;
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] status_q;
    logic               err_q;

    always_comb begin
        addr_ok  = ev_valid && (ev_addr == tgt_addr);
        in_range = ev_data < DATA_W'(NUM_VEC);
        hit      = addr_ok && in_range;
    end

    for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_set
        assign set_vec[gi] = hit && (ev_data[IDX_W-1:0] == IDX_W'(gi));

        // R5: a capture always lands, even against a clear
        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[gi] |=> status_q[gi]);
        // R4: a vector bit only drops after a write-one clear
        a_r4_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_q[gi]) |-> $past(clr_vec[gi]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            err_q    <= 1'b0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
            if (addr_ok && !in_range)
                err_q <= 1'b1;
        end
    end

    assign status = status_q;
    assign err    = err_q;

    // R10: error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/intx_latch.sv
module intx_latch #(
    parameter int INTX_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTX_N-1:0] lvl,
    input  logic [INTX_N-1:0] clr,
    output logic [INTX_N-1:0] status
);
    logic [INTX_N-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr) | lvl;
    end

    assign status = status_q;

    for (genvar gi = 0; gi < INTX_N; gi++) begin : g_chk
        // R6: an asserted level is never lost to a clear
        a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
            lvl[gi] |=> status_q[gi]);
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import msi_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

    // R9: output follows the pending OR one clock later
    a_r9_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(pending)));
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
    import msi_agg_pkg::*;
#(
    parameter int VEC_N  = NUM_VEC,
    parameter int DW     = DATA_W,
    parameter int INTX_W = INTX_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    input  logic [DW-1:0]     msi_addr,
    input  logic [DW-1:0]     msi_data,
    input  logic [INTX_W-1:0] intx_lvl,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              host_irq
);
    localparam logic [DW-1:0] MASK_BITS =
        (DW'((1 << INTX_W) - 1) << INTX_LSB) | (DW'(1) << MSI_SUM_BIT);

    logic [DW-1:0]     mask_q;
    logic [DW-1:0]     tgt_q;
    logic              summary_q;
    logic [VEC_N-1:0]  vec_status;
    logic [VEC_N-1:0]  vec_clr;
    logic [INTX_W-1:0] intx_status;
    logic [INTX_W-1:0] intx_clr;
    logic              cap_hit;
    logic              cap_err;
    logic              wr_vec;
    logic              wr_stat;
    logic [DW-1:0]     shared_stat;
    logic              pending;

    always_comb begin
        wr_vec   = reg_wr && (reg_addr == OFS_VEC_STAT);
        wr_stat  = reg_wr && (reg_addr == OFS_IRQ_STAT);
        vec_clr  = wr_vec  ? reg_wdata[VEC_N-1:0] : '0;
        intx_clr = wr_stat ? reg_wdata[INTX_LSB +: INTX_W] : '0;
    end

    msi_vec_capture #(.NUM_VEC(VEC_N), .DATA_W(DW)) i_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (msi_valid),
        .ev_addr  (msi_addr),
        .ev_data  (msi_data),
        .tgt_addr (tgt_q),
        .clr_vec  (vec_clr),
        .status   (vec_status),
        .hit      (cap_hit),
        .err      (cap_err)
    );

    intx_latch #(.INTX_N(INTX_W)) i_intx (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (intx_lvl),
        .clr    (intx_clr),
        .status (intx_status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            summary_q <= 1'b0;
            mask_q    <= MASK_BITS;
            tgt_q     <= '0;
        end else begin
            if (cap_hit)
                summary_q <= 1'b1;
            else if (wr_stat && reg_wdata[MSI_SUM_BIT] && (vec_status == '0))
                summary_q <= 1'b0;
            if (reg_wr && (reg_addr == OFS_IRQ_MASK))
                mask_q <= reg_wdata & MASK_BITS;
            if (reg_wr && (reg_addr == OFS_MSI_TGT))
                tgt_q <= reg_wdata;
        end
    end

    always_comb begin
        shared_stat                        = '0;
        shared_stat[INTX_LSB +: INTX_W]    = intx_status;
        shared_stat[MSI_SUM_BIT]           = summary_q;
        pending                            = |(shared_stat & ~mask_q);
    end

    always_comb begin
        case (reg_addr)
            OFS_VEC_STAT: reg_rdata = DW'(vec_status);
            OFS_IRQ_STAT: reg_rdata = shared_stat;
            OFS_IRQ_MASK: reg_rdata = mask_q;
            OFS_MSI_TGT:  reg_rdata = tgt_q;
            OFS_DEBUG:    reg_rdata = DW'(cap_err);
            default:      reg_rdata = '0;
        endcase
    end

    irq_ctrl i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (host_irq)
    );

    // R7: summary never falls while vectors are pending
    a_r7_summary_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(summary_q) |-> ($past(vec_status) == '0));
    // R7: every capture raises the summary
    a_r7_summary_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> summary_q);
    // R2: a capture shows in the vector register on the next cycle
    a_r2_capture_visible: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (vec_status != '0));
endmodule

// File: tb/test_msi_irq_agg.sv
`timescale 1ns/1ps
module test_msi_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic [3:0]  intx_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msi_irq_agg i_msi_irq_agg (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .intx_lvl(intx_lvl), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq(host_irq)
    );

    // behavioural reference model
    logic [31:0] m_vec, m_mask, m_tgt;
    logic [3:0]  m_intx;
    logic        m_sum, m_err, m_irq;

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_vec;
            5'h04: return {8'h0, m_sum, 3'b0, m_intx, 16'h0};
            5'h08: return m_mask;
            5'h0C: return m_tgt;
            5'h10: return {31'h0, m_err};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vec = 0; m_mask = 32'h008F0000; m_tgt = 0; m_intx = 0;
            m_sum = 0; m_err = 0; m_irq = 0;
        end else begin
            logic hitm, badm, wst;
            logic [31:0] stat;
            hitm = msi_valid && msi_addr == m_tgt && msi_data < 32;
            badm = msi_valid && msi_addr == m_tgt && msi_data >= 32;
            wst  = reg_wr && reg_addr == 5'h04;
            stat = m_read(5'h04);
            m_irq = |(stat & ~m_mask);
            if (hitm) m_sum = 1;
            else if (wst && reg_wdata[23] && m_vec == 0) m_sum = 0;
            m_vec = (m_vec & ~((reg_wr && reg_addr == 5'h00) ? reg_wdata : 32'h0))
                    | (hitm ? (32'h1 << msi_data[4:0]) : 32'h0);
            m_intx = (m_intx & ~(wst ? reg_wdata[19:16] : 4'h0)) | intx_lvl;
            if (reg_wr && reg_addr == 5'h08) m_mask = reg_wdata & 32'h008F0000;
            if (reg_wr && reg_addr == 5'h0C) m_tgt = reg_wdata;
            if (badm) m_err = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            chk("MODEL rdata", reg_rdata, m_read(reg_addr));
            chk("R9 MODEL host_irq", {31'h0, host_irq}, {31'h0, m_irq});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic msi(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); msi_valid = 1; msi_addr = a; msi_data = d;
        @(negedge clk); msi_valid = 0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #2;
        chk(tag, reg_rdata, exp);
    endtask

    localparam logic [31:0] TGT = 32'h8000_0040;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(5'h00, 0, "R1 vec status");
        rd(5'h04, 0, "R1 shared status");
        rd(5'h08, 32'h008F0000, "R1 mask");
        rd(5'h10, 0, "R1 debug");
        chk("R1 host_irq", {31'h0, host_irq}, 0);

        wr(5'h0C, TGT);
        rd(5'h0C, TGT, "R11 target");

        msi(TGT, 5);
        rd(5'h00, 32'h20, "R2 capture vector 5");
        rd(5'h04, 32'h00800000, "R7 summary set");
        msi(TGT + 4, 7);
        rd(5'h00, 32'h20, "R3 mismatched address");
        msi(TGT, 0);
        msi(TGT, 31);
        rd(5'h00, 32'h80000021, "R2 vectors 0 and 31");
        msi(TGT, 32);
        msi(TGT, 32'h105);
        rd(5'h00, 32'h80000021, "R10 out-of-range ignored");
        rd(5'h10, 1, "R10 error flag");

        wr(5'h00, 0);
        rd(5'h00, 32'h80000021, "R4 zero write");
        wr(5'h00, 1);
        rd(5'h00, 32'h80000020, "R4 clear bit 0");

        // capture and clear of vector 5 on the same edge
        @(negedge clk); msi_valid = 1; msi_addr = TGT; msi_data = 5;
        reg_wr = 1; reg_addr = 5'h00; reg_wdata = 32'h20;
        @(negedge clk); msi_valid = 0; reg_wr = 0;
        rd(5'h00, 32'h80000020, "R5 set wins");

        wr(5'h04, 32'h00800000);
        rd(5'h04, 32'h00800000, "R7 clear refused while pending");
        wr(5'h00, 32'h80000020);
        rd(5'h00, 0, "R4 drained");
        wr(5'h04, 32'h00800000);
        rd(5'h04, 0, "R7 clear after drain");
        chk("R9 masked no irq", {31'h0, host_irq}, 0);

        msi(TGT, 3);
        wr(5'h08, 32'h000F0000);
        #2 chk("R9 latency", {31'h0, host_irq}, 0);
        @(negedge clk); #2 chk("R9 irq raised", {31'h0, host_irq}, 1);
        wr(5'h08, 32'h008F0000);
        wr(5'h00, 32'h8);
        wr(5'h04, 32'h00800000);
        rd(5'h04, 0, "R7 summary cleared");

        @(negedge clk); intx_lvl = 4'b0010;
        @(negedge clk); intx_lvl = 0;
        rd(5'h04, 32'h00020000, "R6 INTx1 latched");
        @(negedge clk); intx_lvl = 4'b1000;
        wr(5'h04, 32'h00080000);
        rd(5'h04, 32'h000A0000, "R6 held while level high");
        @(negedge clk); intx_lvl = 0;
        wr(5'h04, 32'h000A0000);
        rd(5'h04, 0, "R6 cleared");

        wr(5'h08, 32'h008D0000);
        rd(5'h08, 32'h008D0000, "R8 mask readback");
        @(negedge clk); intx_lvl = 4'b0001;
        @(negedge clk); intx_lvl = 0;
        @(negedge clk); #2 chk("R8 masked INTx0 no irq", {31'h0, host_irq}, 0);
        @(negedge clk); intx_lvl = 4'b0010;
        @(negedge clk); intx_lvl = 0;
        @(negedge clk); #2 chk("R8 unmasked INTx1 irq", {31'h0, host_irq}, 1);
        wr(5'h04, 32'h00030000);
        @(negedge clk); #2 chk("R9 irq drops", {31'h0, host_irq}, 0);
        wr(5'h08, 32'hFFFFFFFF);
        rd(5'h08, 32'h008F0000, "R8 only mask bits kept");

        wr(5'h10, 0);
        rd(5'h10, 1, "R10 debug write ignored");
        rd(5'h14, 0, "R11 unmapped offset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule